// File: doc/BRIEF.md
# Addressed Serial Register Slave with Pause and Write Guard

This block is the serial front end of a four-channel setting device. A host selects it with an active-low select line. It clocks in one instruction byte, most significant bit first, and then either a data byte to write or a data byte it reads back. Each channel has two 8-bit registers:

- a volatile wiper register, which drives the channel's output value at once;
- a data register that stands for non-volatile storage.

Writes to a data register are only staged during the transaction. They are committed when select is released, and the commit starts an internal write cycle of fixed length that shows on a busy flag.

The serial pins are asynchronous to the block's system clock. Serial clock, select, serial input, hold and write guard each pass through a two-flop synchroniser. Edges of the serial clock and of select are detected in the system-clock domain. A hold input pauses a transaction part way and later resumes it. A write-guard input blocks data-register commits but leaves wiper writes alone. Two strap inputs let four such devices share one bus.

Instruction byte, from the first bit sent: operation code in bits 7..4, device address in bits 3..2, channel select in bits 1..0. Operation codes:

| Code | Operation |
|------|-----------|
| 0x9 | read wiper |
| 0xA | write wiper |
| 0xB | read data register |
| 0xC | write data register |
| 0xD | copy data register to wiper |

Any other code is ignored for the rest of the transaction.

Top module: `spi_pot_slave`

## Requirements
- R1: After reset, every wiper and data register is 0, `nv_busy` is 0 and `miso_oe` is 0.
- R2: An instruction with code 0xA, a matching address and channel c, followed by 8 data bits, loads that byte into wiper c. The new value appears on `wiper_o` before select is released.
- R3: `mosi` is taken on rising serial-clock edges and `miso` changes only after falling edges. For codes 0x9 and 0xB, the selected byte is returned MSB first on the 8 rising edges after the instruction byte, with `miso_oe` high.
- R4: An instruction whose address bits 3..2 differ from `dev_strap` has no effect on any register, and `miso_oe` stays 0.
- R5: Code 0xC with 8 data bits stages a write. The rise of select commits it to data register c and holds `nv_busy` high for exactly NVW_CYCLES system clocks.
- R6: If `wp_n` is low when select rises, a staged data write is dropped and `nv_busy` stays 0. Wiper writes under a low `wp_n` still take effect.
- R7: If `wp_n` is seen low at any time while select is low, a staged data write is dropped, even when `wp_n` is high again by the time select rises.
- R8: Once the internal write cycle has begun, `wp_n` going low neither stops it nor undoes the committed value.
- R9: Write instructions (0xA, 0xC) decoded while `nv_busy` is high are ignored.
- R10: Hold taken low while the serial clock is low pauses the transaction. While paused, `miso_oe` is 0 and serial-clock and `mosi` activity is ignored. Hold going high while the serial clock is low resumes at the same bit.
- R11: Hold changes made while the serial clock is high have no effect on the transaction.
- R12: Code 0xD copies data register c into wiper c.
- R13: While select is high, `miso_oe` is 0 and no register changes. A transaction cut short before its last bit changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause request |
| wp_n | input | 1 | Active-low data-register write guard |
| dev_strap | input | 2 | Device address straps |
| miso | output | 1 | Serial data out value |
| miso_oe | output | 1 | Output enable for the `miso` pad buffer (0 = high impedance) |
| nv_busy | output | 1 | Internal write cycle in progress |
| wiper_o | output | NCH*DW | Wiper register values, channel 0 in the low byte |

## Verification
A level change on any serial pin reaches the control logic two system clocks later, and a serial-clock or select edge is acted on one clock after that. `miso` therefore moves about four clocks after a falling pin edge. A committed write raises `nv_busy` about five clocks after select rises, and `nv_busy` then stays high for exactly NVW_CYCLES clocks. The bench holds each serial-clock half period for eight system clocks and samples `miso` at the end of the low half, just before it raises the clock, so every result has settled well before it is read. Busy length is measured by counting high cycles over a window wider than the write cycle plus the pipeline delay. Checks for "no effect" read the register back in a later transaction.

// File: rtl/spi_pot_pkg.sv
package spi_pot_pkg;

    localparam int OP_W    = 4;
    localparam int DEV_W   = 2;
    localparam int SEL_W   = 2;
    localparam int INSTR_W = OP_W + DEV_W + SEL_W;

    typedef enum logic [OP_W-1:0] {
        OP_RD_WIPER = 4'h9,
        OP_WR_WIPER = 4'hA,
        OP_RD_DATA  = 4'hB,
        OP_WR_DATA  = 4'hC,
        OP_COPY     = 4'hD
    } op_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [DEV_W-1:0] dev;
        logic [SEL_W-1:0] sel;
    } instr_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_DIN,
        PH_DOUT,
        PH_SKIP
    } phase_e;

    function automatic logic is_write_op(input logic [OP_W-1:0] op);
        return (op == OP_WR_WIPER) || (op == OP_WR_DATA);
    endfunction

    function automatic logic is_read_op(input logic [OP_W-1:0] op);
        return (op == OP_RD_WIPER) || (op == OP_RD_DATA);
    endfunction

endpackage

// File: rtl/spi_pot_sync.sv
module spi_pot_sync #(
    parameter int       W      = 1,
    parameter int       STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= din;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_pot_regs.sv
module spi_pot_regs
    import spi_pot_pkg::*;
#(
    parameter int DW         = 8,
    parameter int NCH        = 4,
    parameter int NVW_CYCLES = 2000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [DW-1:0]        wr_val,
    input  logic                 copy_en,
    input  logic [SEL_W-1:0]     copy_sel,
    input  logic                 commit_en,
    input  logic [SEL_W-1:0]     commit_sel,
    input  logic [DW-1:0]        commit_val,
    output logic [NCH*DW-1:0]    wiper_q,
    output logic [NCH*DW-1:0]    data_q,
    output logic                 busy
);
    localparam int BC_W = $clog2(NVW_CYCLES + 1);

    logic [BC_W-1:0] busy_cnt;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [DW-1:0] wip;
        logic [DW-1:0] dat;

        always_ff @(posedge clk) begin
            if (rst) begin
                wip <= '0;
                dat <= '0;
            end else begin
                if (wr_en && wr_sel == SEL_W'(c))
                    wip <= wr_val;
                else if (copy_en && copy_sel == SEL_W'(c))
                    wip <= dat;
                if (commit_en && commit_sel == SEL_W'(c))
                    dat <= commit_val;
            end
        end

        assign wiper_q[c*DW +: DW] = wip;
        assign data_q[c*DW +: DW]  = dat;
    end

    always_ff @(posedge clk) begin
        if (rst)
            busy_cnt <= '0;
        else if (commit_en)
            busy_cnt <= BC_W'(NVW_CYCLES);
        else if (busy_cnt != '0)
            busy_cnt <= busy_cnt - 1'b1;
    end

    assign busy = (busy_cnt != '0);
endmodule

// File: rtl/spi_pot_ctrl.sv
module spi_pot_ctrl
    import spi_pot_pkg::*;
#(
    parameter int DW  = 8,
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_lvl,
    input  logic              cs_lvl,
    input  logic              mosi_lvl,
    input  logic              hold_lvl,
    input  logic              wp_lvl,
    input  logic [DEV_W-1:0]  dev_strap,
    input  logic              busy,
    input  logic [NCH*DW-1:0] wiper_rd,
    input  logic [NCH*DW-1:0] data_rd,
    output logic              miso,
    output logic              miso_oe,
    output logic              paused,
    output logic              wr_en,
    output logic [SEL_W-1:0]  wr_sel,
    output logic [DW-1:0]     wr_val,
    output logic              copy_en,
    output logic [SEL_W-1:0]  copy_sel,
    output logic              commit_en,
    output logic [SEL_W-1:0]  commit_sel,
    output logic [DW-1:0]     commit_val
);
    localparam int MAXB  = (INSTR_W > DW) ? INSTR_W : DW;
    localparam int CNT_W = $clog2(MAXB);

    phase_e              phase;
    instr_t              cur;
    logic [CNT_W-1:0]    bit_cnt;
    logic [INSTR_W-1:0]  cmd_sh;
    logic [DW-1:0]       din_sh;
    logic [DW-1:0]       dout_sh;
    logic                sck_d, cs_d;
    logic                reading;
    logic                stage_v;
    logic                wp_seen_low;
    logic [SEL_W-1:0]    stage_sel;
    logic [DW-1:0]       stage_val;

    logic                act, sck_up, sck_dn, cs_up, cs_dn;
    logic [INSTR_W-1:0]  cmd_next;
    logic [DW-1:0]       din_next;
    instr_t              dec;

    assign act      = ~cs_lvl;
    assign sck_up   = sck_lvl & ~sck_d & act & ~paused;
    assign sck_dn   = ~sck_lvl & sck_d & act & ~paused;
    assign cs_up    = cs_lvl & ~cs_d;
    assign cs_dn    = ~cs_lvl & cs_d;
    assign cmd_next = {cmd_sh[INSTR_W-2:0], mosi_lvl};
    assign din_next = {din_sh[DW-2:0], mosi_lvl};
    assign dec      = instr_t'(cmd_next);
    assign miso_oe  = act & ~paused & reading;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            cur         <= '0;
            bit_cnt     <= '0;
            cmd_sh      <= '0;
            din_sh      <= '0;
            dout_sh     <= '0;
            sck_d       <= 1'b0;
            cs_d        <= 1'b1;
            reading     <= 1'b0;
            stage_v     <= 1'b0;
            wp_seen_low <= 1'b0;
            stage_sel   <= '0;
            stage_val   <= '0;
            paused      <= 1'b0;
            miso        <= 1'b0;
            wr_en       <= 1'b0;
            wr_sel      <= '0;
            wr_val      <= '0;
            copy_en     <= 1'b0;
            copy_sel    <= '0;
            commit_en   <= 1'b0;
            commit_sel  <= '0;
            commit_val  <= '0;
        end else begin
            sck_d     <= sck_lvl;
            cs_d      <= cs_lvl;
            wr_en     <= 1'b0;
            copy_en   <= 1'b0;
            commit_en <= 1'b0;

            // pause state only follows hold while the serial clock is low
            if (!act)
                paused <= 1'b0;
            else if (!sck_lvl)
                paused <= ~hold_lvl;

            if (cs_dn) begin
                phase       <= PH_CMD;
                bit_cnt     <= '0;
                reading     <= 1'b0;
                stage_v     <= 1'b0;
                wp_seen_low <= ~wp_lvl;
            end else if (!act) begin
                phase   <= PH_IDLE;
                reading <= 1'b0;
                stage_v <= 1'b0;
                if (cs_up && stage_v && !wp_seen_low && wp_lvl && !busy) begin
                    commit_en  <= 1'b1;
                    commit_sel <= stage_sel;
                    commit_val <= stage_val;
                end
            end else begin
                if (!wp_lvl)
                    wp_seen_low <= 1'b1;

                if (sck_up) begin
                    case (phase)
                        PH_CMD: begin
                            cmd_sh <= cmd_next;
                            if (bit_cnt == CNT_W'(INSTR_W-1)) begin
                                bit_cnt <= '0;
                                cur     <= dec;
                                if (dec.dev != dev_strap) begin
                                    phase <= PH_SKIP;
                                end else if (is_read_op(dec.op)) begin
                                    reading <= 1'b1;
                                    phase   <= PH_DOUT;
                                    dout_sh <= (dec.op == OP_RD_WIPER)
                                             ? wiper_rd[int'(dec.sel)*DW +: DW]
                                             : data_rd[int'(dec.sel)*DW +: DW];
                                end else if (is_write_op(dec.op)) begin
                                    phase <= busy ? PH_SKIP : PH_DIN;
                                end else if (dec.op == OP_COPY) begin
                                    copy_en  <= 1'b1;
                                    copy_sel <= dec.sel;
                                    phase    <= PH_SKIP;
                                end else begin
                                    phase <= PH_SKIP;
                                end
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                        PH_DIN: begin
                            din_sh <= din_next;
                            if (bit_cnt == CNT_W'(DW-1)) begin
                                phase <= PH_SKIP;
                                if (cur.op == OP_WR_WIPER) begin
                                    wr_en  <= 1'b1;
                                    wr_sel <= cur.sel;
                                    wr_val <= din_next;
                                end else begin
                                    stage_v   <= 1'b1;
                                    stage_sel <= cur.sel;
                                    stage_val <= din_next;
                                end
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end

                if (sck_dn && phase == PH_DOUT) begin
                    miso    <= dout_sh[DW-1];
                    dout_sh <= {dout_sh[DW-2:0], 1'b0};
                    if (bit_cnt == CNT_W'(DW-1))
                        phase <= PH_SKIP;
                    else
                        bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_pot_slave.sv
module spi_pot_slave
    import spi_pot_pkg::*;
#(
    parameter int DW         = 8,
    parameter int NCH        = 4,
    parameter int NVW_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              hold_n,
    input  logic              wp_n,
    input  logic [1:0]        dev_strap,
    output logic              miso,
    output logic              miso_oe,
    output logic              nv_busy,
    output logic [NCH*DW-1:0] wiper_o
);
    localparam int NPIN = 5;
    // pin order: wp_n, hold_n, mosi, cs_n, sck
    localparam logic [NPIN-1:0] PIN_IDLE = 5'b11010;

    logic [NPIN-1:0]   pins_lvl;
    logic              sck_lvl, cs_lvl, mosi_lvl, hold_lvl, wp_lvl;
    logic              paused;
    logic              wr_en, copy_en, commit_en;
    logic [SEL_W-1:0]  wr_sel, copy_sel, commit_sel;
    logic [DW-1:0]     wr_val, commit_val;
    logic [NCH*DW-1:0] data_q;

    spi_pot_sync #(.W(NPIN), .STAGES(2), .RST_VAL(PIN_IDLE)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  ({wp_n, hold_n, mosi, cs_n, sck}),
        .dout (pins_lvl)
    );

    assign {wp_lvl, hold_lvl, mosi_lvl, cs_lvl, sck_lvl} = pins_lvl;

    spi_pot_ctrl #(.DW(DW), .NCH(NCH)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .sck_lvl    (sck_lvl),
        .cs_lvl     (cs_lvl),
        .mosi_lvl   (mosi_lvl),
        .hold_lvl   (hold_lvl),
        .wp_lvl     (wp_lvl),
        .dev_strap  (dev_strap),
        .busy       (nv_busy),
        .wiper_rd   (wiper_o),
        .data_rd    (data_q),
        .miso       (miso),
        .miso_oe    (miso_oe),
        .paused     (paused),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_val     (wr_val),
        .copy_en    (copy_en),
        .copy_sel   (copy_sel),
        .commit_en  (commit_en),
        .commit_sel (commit_sel),
        .commit_val (commit_val)
    );

    spi_pot_regs #(.DW(DW), .NCH(NCH), .NVW_CYCLES(NVW_CYCLES)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_val     (wr_val),
        .copy_en    (copy_en),
        .copy_sel   (copy_sel),
        .commit_en  (commit_en),
        .commit_sel (commit_sel),
        .commit_val (commit_val),
        .wiper_q    (wiper_o),
        .data_q     (data_q),
        .busy       (nv_busy)
    );
endmodule

// File: rtl/spi_pot_slave_chk.sv
module spi_pot_slave_chk #(
    parameter int WW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_lvl,
    input logic          sck_lvl,
    input logic          wp_lvl,
    input logic          paused,
    input logic          miso,
    input logic          miso_oe,
    input logic          busy,
    input logic          commit_en,
    input logic          wr_en,
    input logic [WW-1:0] wiper
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !miso_oe));

    // R3
    miso_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !(!sck_lvl && $past(sck_lvl)) |=> $stable(miso));

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(commit_en));

    // R6
    wp_commit_chk: assert property (@(posedge clk) disable iff (rst)
        commit_en |-> $past(wp_lvl));

    // R9
    busy_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!commit_en && !wr_en));

    // R10
    pause_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        paused |=> $stable(miso));

    // R11
    hold_sck_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(cs_lvl) && $past(sck_lvl)) |-> $stable(paused));

    // R13
    deselect_still_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cs_lvl) |=> $stable(wiper));
endmodule

bind spi_pot_slave spi_pot_slave_chk #(.WW(NCH*DW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cs_lvl    (cs_lvl),
    .sck_lvl   (sck_lvl),
    .wp_lvl    (wp_lvl),
    .paused    (paused),
    .miso      (miso),
    .miso_oe   (miso_oe),
    .busy      (nv_busy),
    .commit_en (commit_en),
    .wr_en     (wr_en),
    .wiper     (wiper_o)
);

// File: tb/spi_pot_slave_tb_top.sv
module spi_pot_slave_tb_top;
    localparam int DW   = 8;
    localparam int NCH  = 4;
    localparam int NVW  = 1000;
    localparam int HALF = 8;
    localparam int NVEC = 15;

    // {is_read, instr, data_in, expected}; device strap is 2'b10
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 8'hA8, 8'hA5, 8'h00},  // R2 write wiper0
        {1'b1, 8'h98, 8'h00, 8'hA5},  // R2 R3 read wiper0
        {1'b0, 8'hAB, 8'h3C, 8'h00},  // write wiper3
        {1'b1, 8'h9B, 8'h00, 8'h3C},  // R3 read wiper3
        {1'b0, 8'hA5, 8'hFF, 8'h00},  // R4 wrong address
        {1'b1, 8'h99, 8'h00, 8'h00},  // R4 wiper1 untouched
        {1'b0, 8'hCA, 8'h81, 8'h00},  // R5 write data2
        {1'b1, 8'hBA, 8'h00, 8'h81},  // R5 read data2
        {1'b0, 8'hDA, 8'h00, 8'h00},  // R12 copy data2 to wiper2
        {1'b1, 8'h9A, 8'h00, 8'h81},  // R12 read wiper2
        {1'b1, 8'hB8, 8'h00, 8'h00},  // R1 data0 still reset value
        {1'b0, 8'hC8, 8'h5A, 8'h00},  // R5 write data0
        {1'b1, 8'hB8, 8'h00, 8'h5A},  // R5 read data0
        {1'b0, 8'h09, 8'h77, 8'h00},  // unknown code
        {1'b1, 8'h99, 8'h00, 8'h00}   // wiper1 untouched
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sck = 1'b0;
    logic              cs_n = 1'b1;
    logic              mosi = 1'b0;
    logic              hold_n = 1'b1;
    logic              wp_n = 1'b1;
    logic [1:0]        dev_strap = 2'b10;
    logic              miso, miso_oe, nv_busy;
    logic [NCH*DW-1:0] wiper_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    spi_pot_slave #(.DW(DW), .NCH(NCH), .NVW_CYCLES(NVW)) dut_i (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .hold_n(hold_n), .wp_n(wp_n), .dev_strap(dev_strap),
        .miso(miso), .miso_oe(miso_oe), .nv_busy(nv_busy), .wiper_o(wiper_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] ins, input logic [7:0] din, input int nbits,
                        input int pause_at, input int glitch_at, input int wp_at,
                        output logic [7:0] dout, output logic oe_seen);
        logic [15:0] word;
        word    = {ins, din};
        dout    = '0;
        oe_seen = 1'b0;
        tick(4);
        cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            mosi = word[15-i];
            tick(HALF);
            if (i == wp_at) begin
                wp_n = 1'b0; tick(3); wp_n = 1'b1; tick(3);
            end
            if (i == pause_at) begin
                hold_n = 1'b0;
                tick(6);
                chk("R10 oe low while paused", {31'd0, miso_oe}, 32'd0);
                for (int k = 0; k < 3; k++) begin
                    mosi = ~mosi; tick(3);
                    sck = 1'b1; tick(6);
                    sck = 1'b0; tick(6);
                end
                mosi = word[15-i];
                hold_n = 1'b1;
                tick(6);
            end
            if (i >= 8) dout[15-i] = miso;
            if (i == 8) oe_seen = miso_oe;
            sck = 1'b1;
            if (i == glitch_at) begin
                tick(2); hold_n = 1'b0; tick(3); hold_n = 1'b1; tick(HALF-5);
            end else begin
                tick(HALF);
            end
            sck = 1'b0;
        end
        tick(HALF);
        cs_n = 1'b1;
        tick(1);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 5000 && nv_busy; k++) tick(1);
        tick(4);
    endtask

    task automatic rd(input logic [7:0] ins, output logic [7:0] v);
        logic oe;
        xfer(ins, 8'h00, 16, -1, -1, -1, v, oe);
    endtask

    task automatic wr(input logic [7:0] ins, input logic [7:0] d);
        logic [7:0] v;
        logic oe;
        xfer(ins, d, 16, -1, -1, -1, v, oe);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: got %0d expected 0", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic oe;
        int cnt;
        tick(6);
        rst = 1'b0;
        tick(4);
        chk("R1 oe", {31'd0, miso_oe}, 32'd0);
        chk("R1 busy", {31'd0, nv_busy}, 32'd0);
        chk("R1 wipers", wiper_o, 32'd0);

        for (int n = 0; n < NVEC; n++) begin
            xfer(VEC[n][23:16], VEC[n][15:8], 16, -1, -1, -1, v, oe);
            if (VEC[n][24]) begin
                chk($sformatf("R3 vector %0d readback", n), {24'd0, v}, {24'd0, VEC[n][7:0]});
                chk($sformatf("R3 vector %0d oe", n), {31'd0, oe}, 32'd1);
            end
            wait_idle();
        end
        chk("R13 oe low after deselect", {31'd0, miso_oe}, 32'd0);
        chk("R2 wiper0 on port", {24'd0, wiper_o[7:0]}, 32'hA5);

        // R5: exact busy length
        wr(8'hC9, 8'h42);
        cnt = 0;
        for (int k = 0; k < NVW + 40; k++) begin
            tick(1);
            if (nv_busy) cnt++;
        end
        chk("R5 busy length", cnt, NVW);
        rd(8'hB9, v);
        chk("R5 data1 committed", {24'd0, v}, 32'h42);

        // R9: writes during busy ignored
        wr(8'hC9, 8'h55);
        wr(8'hA9, 8'hEE);
        chk("R9 still busy after wiper write", {31'd0, nv_busy}, 32'd1);
        wr(8'hCB, 8'h99);
        wait_idle();
        tick(20);
        chk("R9 no second commit", {31'd0, nv_busy}, 32'd0);
        rd(8'h99, v);
        chk("R9 wiper1 unchanged", {24'd0, v}, 32'h00);
        rd(8'hBB, v);
        chk("R9 data3 unchanged", {24'd0, v}, 32'h00);
        rd(8'hB9, v);
        chk("R5 data1 second commit", {24'd0, v}, 32'h55);

        // R6: guard low at commit, wiper writes still allowed
        wp_n = 1'b0;
        wr(8'hCB, 8'h11);
        tick(20);
        chk("R6 no busy under guard", {31'd0, nv_busy}, 32'd0);
        wr(8'hAB, 8'h22);
        wp_n = 1'b1;
        rd(8'hBB, v);
        chk("R6 data3 blocked", {24'd0, v}, 32'h00);
        rd(8'h9B, v);
        chk("R6 wiper3 written under guard", {24'd0, v}, 32'h22);

        // R7: guard pulse mid transaction
        xfer(8'hCB, 8'h33, 16, -1, -1, 12, v, oe);
        tick(20);
        chk("R7 no busy after guard pulse", {31'd0, nv_busy}, 32'd0);
        rd(8'hBB, v);
        chk("R7 data3 abandoned", {24'd0, v}, 32'h00);

        // R8: guard during write cycle
        wr(8'hC8, 8'h44);
        tick(20);
        wp_n = 1'b0;
        tick(20);
        chk("R8 busy continues", {31'd0, nv_busy}, 32'd1);
        wp_n = 1'b1;
        wait_idle();
        rd(8'hB8, v);
        chk("R8 data0 kept", {24'd0, v}, 32'h44);

        // R10: pause inside a read and inside a write
        xfer(8'h98, 8'h00, 16, 11, -1, -1, v, oe);
        chk("R10 read across pause", {24'd0, v}, 32'hA5);
        chk("R3 oe during read", {31'd0, oe}, 32'd1);
        xfer(8'hAA, 8'h6E, 16, 12, -1, -1, v, oe);
        rd(8'h9A, v);
        chk("R10 write across pause", {24'd0, v}, 32'h6E);

        // R11: hold glitch with serial clock high
        xfer(8'hAB, 8'h77, 16, -1, 10, -1, v, oe);
        rd(8'h9B, v);
        chk("R11 hold ignored while clock high", {24'd0, v}, 32'h77);

        // R13: cut-short transactions
        xfer(8'hA8, 8'h00, 12, -1, -1, -1, v, oe);
        rd(8'h98, v);
        chk("R13 short wiper write", {24'd0, v}, 32'hA5);
        xfer(8'hC8, 8'h00, 12, -1, -1, -1, v, oe);
        tick(20);
        chk("R13 short data write no busy", {31'd0, nv_busy}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule